// File: doc/BRIEF.md
# Nested Loop Hang Detector

This block watches loop boundaries reported at instruction commit and flags a loop that has run past its time budget. Each loop-start event carries its own budget in clock cycles. The block keeps one down-counting timer for each supported nesting level. A small state machine holds the current nesting depth and picks which timer to load or to stop.

On a loop start, the timer one level below the current depth is loaded with the event's budget and the depth goes up by one. On a loop end, the innermost running timer is stopped and the depth goes down by one. Outer timers keep counting while inner loops run, because an outer budget includes the inner work. When any running timer reaches zero, the block raises a sticky hang error and records the nesting level of that timer. A start event that would go deeper than the supported depth, or an end event with no loop open, raises a separate sticky nesting error and leaves the depth unchanged.

Events arrive on a valid/ready port. The block never applies back-pressure: `evt_ready` is high whenever the block is out of reset. An event is taken on every rising clock edge where `evt_valid` and `evt_ready` are both high.

Top module: `loop_hang_monitor`

## Requirements
- R1: After reset, `depth` is 0, `hang_err`, `hang_level` and `nest_err` are 0, and `evt_ready` is 1.
- R2: An accepted event with `evt_is_end`=0 at depth d < DEPTH loads the timer of level d+1 with `evt_budget` = B and makes `depth` d+1 on the next cycle. If no end event follows, `hang_err` rises on the (B+1)th rising edge after the accepting edge.
- R3: An accepted event with `evt_is_end`=1 at depth d > 0 stops the timer of level d and makes `depth` d-1 on the next cycle. A timer stopped before it reaches zero never raises `hang_err`.
- R4: The timers of outer levels keep counting while deeper levels are open and after those levels end.
- R5: A start event with budget 0 makes `hang_err` rise on the first rising edge after the accepting edge.
- R6: A start event accepted at depth DEPTH leaves `depth` unchanged, loads no timer, and sets `nest_err`.
- R7: An end event accepted at depth 0 leaves `depth` unchanged and sets `nest_err`.
- R8: `hang_err` and `nest_err` stay at 1 until reset. `hang_level` holds the level (1 to DEPTH) of the first timer that expired. If several timers expire in the same cycle, it holds the lowest of those levels.
- R9: `evt_ready` stays at 1. Inputs presented while `evt_valid` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Loop event present |
| evt_ready | output | 1 | Block accepts the event (always 1) |
| evt_is_end | input | 1 | 0 = loop start, 1 = loop end |
| evt_budget | input | TW | Budget in cycles, used on loop start |
| depth | output | LW | Current nesting depth, 0 to DEPTH |
| hang_err | output | 1 | Sticky: a loop timer expired |
| hang_level | output | LW | Level of the first expired timer |
| nest_err | output | 1 | Sticky: nesting overflow or underflow |

## Verification
The hardest case to reach is two timers at different levels hitting zero in the same cycle, which decides the priority rule for `hang_level`. The bench reaches it by issuing back-to-back start events whose budgets differ by exactly one cycle, so the outer and inner timers reach zero together. Reaching an outer timer's expiry while an inner level is open also depends on exact cycle counting. The bench plans every event edge relative to the accepting edge so that it knows which cycle should show the error.

// File: rtl/lhm_pkg.sv
package lhm_pkg;
  typedef enum logic {
    EV_START = 1'b0,
    EV_END   = 1'b1
  } ev_kind_t;
endpackage

// File: rtl/lhm_depth_fsm.sv
module lhm_depth_fsm #(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  lhm_pkg::ev_kind_t kind,
  output logic [LW-1:0]    depth_q,
  output logic [DEPTH-1:0] load_vec,
  output logic [DEPTH-1:0] stop_vec,
  output logic             nest_err_q
);
  import lhm_pkg::*;

  logic full, empty, is_start, is_end;
  assign full     = (depth_q == LW'(DEPTH));
  assign empty    = (depth_q == '0);
  assign is_start = acc && (kind == EV_START);
  assign is_end   = acc && (kind == EV_END);

  for (genvar g = 0; g < DEPTH; g++) begin : g_sel
    assign load_vec[g] = is_start && !full  && (depth_q == LW'(g));
    assign stop_vec[g] = is_end   && !empty && (depth_q == LW'(g + 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q    <= '0;
      nest_err_q <= 1'b0;
    end else begin
      if (is_start) begin
        if (full) nest_err_q <= 1'b1;
        else      depth_q    <= depth_q + 1'b1;
      end else if (is_end) begin
        if (empty) nest_err_q <= 1'b1;
        else       depth_q    <= depth_q - 1'b1;
      end
    end
  end

  a_r2_depth_up: assert property (@(posedge clk) disable iff (!rst_n)
    (is_start && !full) |=> (depth_q == $past(depth_q) + 1'b1));
  a_r3_depth_down: assert property (@(posedge clk) disable iff (!rst_n)
    (is_end && !empty) |=> (depth_q == $past(depth_q) - 1'b1));
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (is_start && full) |=> ($stable(depth_q) && nest_err_q));
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (is_end && empty) |=> ($stable(depth_q) && nest_err_q));
  a_r6_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec | stop_vec));
endmodule

// File: rtl/lhm_timer.sv
module lhm_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          stop,
  input  logic [TW-1:0] budget,
  output logic          expire
);
  logic [TW-1:0] cnt_q;
  logic          run_q;

  assign expire = run_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= budget;
      run_q <= 1'b1;
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r5_zero_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (load && budget == '0) |=> expire);
  a_r3_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load) |=> !expire);
  a_r2_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !expire);
endmodule

// File: rtl/lhm_err_latch.sv
module lhm_err_latch #(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] expire_vec,
  output logic             hang_q,
  output logic [LW-1:0]    level_q
);
  logic [LW-1:0] first_lvl;

  always_comb begin
    first_lvl = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (expire_vec[i]) first_lvl = LW'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hang_q  <= 1'b0;
      level_q <= '0;
    end else if (!hang_q && (expire_vec != '0)) begin
      hang_q  <= 1'b1;
      level_q <= first_lvl;
    end
  end

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hang_q |=> (hang_q && $stable(level_q)));
  a_r8_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    hang_q |-> (level_q != '0 && level_q <= LW'(DEPTH)));
endmodule

// File: rtl/loop_hang_monitor.sv
module loop_hang_monitor #(
  parameter int DEPTH = 4,
  parameter int TW = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  output logic          evt_ready,
  input  logic          evt_is_end,
  input  logic [TW-1:0] evt_budget,
  output logic [LW-1:0] depth,
  output logic          hang_err,
  output logic [LW-1:0] hang_level,
  output logic          nest_err
);
  import lhm_pkg::*;

  logic             acc;
  ev_kind_t         kind;
  logic [DEPTH-1:0] load_vec, stop_vec, expire_vec;

  assign evt_ready = 1'b1;
  assign acc       = evt_valid && evt_ready;
  assign kind      = evt_is_end ? EV_END : EV_START;

  lhm_depth_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .acc(acc), .kind(kind),
    .depth_q(depth), .load_vec(load_vec), .stop_vec(stop_vec),
    .nest_err_q(nest_err)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_tmr
    lhm_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(load_vec[g]), .stop(stop_vec[g]),
      .budget(evt_budget), .expire(expire_vec[g])
    );
  end

  lhm_err_latch #(.DEPTH(DEPTH)) u_err (
    .clk(clk), .rst_n(rst_n), .expire_vec(expire_vec),
    .hang_q(hang_err), .level_q(hang_level)
  );

  a_r8_nest_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    nest_err |=> nest_err);
  a_r9_idle_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> $stable(depth));
endmodule

// File: tb/loop_hang_monitor_tb_top.sv
module loop_hang_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int TW = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic evt_is_end = 1'b0;
  logic [TW-1:0] evt_budget = '0;
  logic evt_ready, hang_err, nest_err;
  logic [LW-1:0] depth, hang_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_hang_monitor #(.DEPTH(DEPTH), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_is_end(evt_is_end), .evt_budget(evt_budget), .depth(depth),
    .hang_err(hang_err), .hang_level(hang_level), .nest_err(nest_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    evt_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // returns at the falling edge just after the accepting rising edge
  task automatic send(input bit is_end, input int budget);
    evt_valid = 1'b1;
    evt_is_end = is_end;
    evt_budget = TW'(budget);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 depth", int'(depth), 0);
    chk("R1 hang_err", int'(hang_err), 0);
    chk("R1 hang_level", int'(hang_level), 0);
    chk("R1 nest_err", int'(nest_err), 0);
    chk("R1 ready", int'(evt_ready), 1);
  endtask

  task automatic t_idle();
    do_reset();
    evt_is_end = 1'b0;
    evt_budget = TW'(0);
    wait_cyc(5);
    chk("R9 depth idle", int'(depth), 0);
    chk("R9 no hang", int'(hang_err), 0);
    chk("R9 ready", int'(evt_ready), 1);
  endtask

  task automatic t_single();
    do_reset();
    send(1'b0, 5);
    chk("R2 depth", int'(depth), 1);
    wait_cyc(5);
    chk("R2 before expiry", int'(hang_err), 0);
    wait_cyc(1);
    chk("R2 expiry", int'(hang_err), 1);
    chk("R8 level", int'(hang_level), 1);
  endtask

  task automatic t_end_before();
    do_reset();
    send(1'b0, 10);
    wait_cyc(3);
    send(1'b1, 0);
    chk("R3 depth", int'(depth), 0);
    wait_cyc(20);
    chk("R3 no hang", int'(hang_err), 0);
    send(1'b0, 3);
    wait_cyc(3);
    chk("R3 reload quiet", int'(hang_err), 0);
    wait_cyc(1);
    chk("R3 reload expiry", int'(hang_err), 1);
  endtask

  task automatic t_nested_outer();
    do_reset();
    send(1'b0, 12);
    send(1'b0, 100);
    chk("R2 depth2", int'(depth), 2);
    wait_cyc(10);
    send(1'b1, 0);
    chk("R4 depth back", int'(depth), 1);
    chk("R4 not yet", int'(hang_err), 0);
    wait_cyc(1);
    chk("R4 outer expiry", int'(hang_err), 1);
    chk("R4 outer level", int'(hang_level), 1);
  endtask

  task automatic t_inner_sticky();
    do_reset();
    send(1'b0, 50);
    send(1'b0, 3);
    wait_cyc(3);
    chk("R2 inner quiet", int'(hang_err), 0);
    wait_cyc(1);
    chk("R2 inner expiry", int'(hang_err), 1);
    chk("R8 inner level", int'(hang_level), 2);
    wait_cyc(60);
    chk("R8 sticky", int'(hang_err), 1);
    chk("R8 level held", int'(hang_level), 2);
  endtask

  task automatic t_simul();
    do_reset();
    send(1'b0, 5);
    send(1'b0, 4);
    wait_cyc(4);
    chk("R8 simul quiet", int'(hang_err), 0);
    wait_cyc(1);
    chk("R8 simul hang", int'(hang_err), 1);
    chk("R8 lowest level", int'(hang_level), 1);
  endtask

  task automatic t_zero();
    do_reset();
    send(1'b0, 0);
    chk("R5 not same cycle", int'(hang_err), 0);
    wait_cyc(1);
    chk("R5 zero expiry", int'(hang_err), 1);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < DEPTH; i++) send(1'b0, 1000);
    chk("R6 full", int'(depth), DEPTH);
    chk("R6 no err yet", int'(nest_err), 0);
    send(1'b0, 0);
    chk("R6 depth held", int'(depth), DEPTH);
    chk("R6 nest_err", int'(nest_err), 1);
    wait_cyc(3);
    chk("R6 no timer loaded", int'(hang_err), 0);
    send(1'b1, 0);
    chk("R6 still pops", int'(depth), DEPTH - 1);
    chk("R8 nest sticky", int'(nest_err), 1);
  endtask

  task automatic t_underflow();
    do_reset();
    send(1'b1, 0);
    chk("R7 depth", int'(depth), 0);
    chk("R7 nest_err", int'(nest_err), 1);
    chk("R7 no hang", int'(hang_err), 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_single();
    t_end_before();
    t_nested_outer();
    t_inner_sticky();
    t_simul();
    t_zero();
    t_overflow();
    t_underflow();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule